// File: doc/BRIEF.md
# Slow Fixed-Period Indicator PWM Generator

This block produces a very slow pulse-width-modulated signal for an indicator such as a status LED. The period is fixed at 2 seconds and is split into 100 steps of 20 ms each. The step length comes from a prescaler on the system clock, set by the `CLK_HZ` parameter. Each period opens with the active phase. During that phase the open-drain pad is pulled low, and for the rest of the period the pad is released. The active phase lasts as many steps as the duty setting in whole percent.

The duty request is clamped into the range 1% to 100%, and at 100% the pad stays pulled low with no gap. A separate "unset" flag overrides the request with a 50% default. The pad is forced to release when any of these holds: the active-low enable input is high, the undervoltage fault is asserted, or the overtemperature fault is asserted. When the block comes back from that blocked state, a new period starts from step zero. A new duty value is taken only at a period boundary or at a restart, so a period that is already running is never cut short. The pad is modelled as a constant low data bit plus an output-enable.

Top module: `slow_pwm_gen`

## Requirements
- R1: One period lasts 100 steps, and one step lasts CLK_HZ/50 clock cycles. A period starts with the active phase (pad_oe = 1), which lasts duty × CLK_HZ/50 cycles; pad_oe is 0 for the rest of the period.
- R2: The request duty_pct is an unsigned 8-bit percentage. A value of 0 is used as 1%, and any value above 100 is used as 100%.
- R3: While duty_unset = 1, duty_pct is ignored and a duty of 50% is used.
- R4: At an effective duty of 100%, pad_oe stays 1 through every cycle of consecutive periods.
- R5: While en_n = 1, pad_oe is 0 in the same cycle, combinationally, without waiting for a clock edge. While en_n = 0, the generator runs.
- R6: While uv_fault = 1 or ot_fault = 1, pad_oe is 0 in the same cycle, combinationally.
- R7: When enable and both faults return to their running values, the period restarts at step zero, so the first period after recovery is complete.
- R8: A change of the duty inputs in the middle of a period takes effect only at the next period boundary.
- R9: While rst_n = 0 at a clock edge, pad_oe is 0. With en_n = 0 and no fault, the generator starts a fresh period in the first cycle after reset is released, without any further setup.
- R10: pad_o is always 0, so the pad is driven only by pulling it low through pad_oe = 1. pad_oe = 0 means the pad is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low run enable |
| uv_fault | input | 1 | Undervoltage fault, active high |
| ot_fault | input | 1 | Overtemperature fault, active high |
| duty_pct | input | 8 | Requested duty in whole percent |
| duty_unset | input | 1 | Use the 50% default duty |
| pad_o | output | 1 | Pad data bit, always low |
| pad_oe | output | 1 | Pad output-enable: 1 pulls the pad low |

## Verification
Some properties are checked by assertions on every cycle:
- the prescaler and step counters stay within range;
- the latched duty stays between 1 and 100;
- the latched duty holds steady between period boundaries;
- the step counter returns to zero after any restart;
- the pad releases while enable is off or a fault is present.

Other behaviour only the bench scenarios can show. These are the exact on-time per period for each duty and clamp case, the 50% default, and the gap-free 100% output over two periods. The bench also shows that a mid-period duty change appears only in the following period, and that a complete first period follows recovery from a fault.

// File: rtl/spg_pkg.sv
// Shared constants and types for the slow PWM generator.
// Assumes duty values never exceed 100, so 7 bits hold them.
package spg_pkg;
    localparam int unsigned STEPS   = 100;
    localparam int unsigned DEF_PCT = 50;
    localparam int unsigned MAX_PCT = 100;
    localparam int unsigned PCT_W   = 7;
    typedef logic [PCT_W-1:0] pct_t;
endpackage

// File: rtl/spg_duty_sel.sv
// Turns the raw duty request into an effective duty between 1 and 100.
// When the unset flag is high, the 50% default is chosen instead.
// Purely combinational; the result is latched downstream.
module spg_duty_sel
    import spg_pkg::*;
#(
    parameter int unsigned REQ_W = 8
) (
    input  logic [REQ_W-1:0] req,
    input  logic             unset,
    output pct_t             pct
);
    localparam logic [REQ_W-1:0] REQ_MAX = REQ_W'(MAX_PCT);

    // Pick the default, the lower floor, the upper clamp or the request as given.
    always_comb begin
        if (unset)
            pct = pct_t'(DEF_PCT);
        else if (req == '0)
            pct = pct_t'(1);
        else if (req > REQ_MAX)
            pct = pct_t'(MAX_PCT);
        else
            pct = pct_t'(req);
    end
endmodule

// File: rtl/spg_prescaler.sv
// Divides the system clock into 20 ms step ticks.
// Assumes CLK_HZ is a multiple of 50. A restart clears the count,
// so the first step after a restart has its full length.
module spg_prescaler #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned STEP_CYC = (CLK_HZ / 50 > 0) ? CLK_HZ / 50 : 1;
    localparam int unsigned CW       = $clog2(STEP_CYC + 1);
    localparam logic [CW-1:0] LAST   = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt;

    // Count cycles inside one step; wrap at the end of the step.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = !restart && (cnt == LAST);

    // R1: the step counter never goes past the last cycle of a step
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/spg_period_ctr.sv
// Counts the 100 steps of a period and latches the duty at each boundary.
// The active phase covers steps 0 .. duty-1. Assumes ticks arrive from
// a prescaler that is cleared by the same restart signal.
module spg_period_ctr
    import spg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    input  pct_t duty_in,
    output logic active
);
    localparam pct_t LAST_STEP = pct_t'(STEPS - 1);

    pct_t step;
    pct_t duty_q;
    logic wrap;

    assign wrap = tick && (step == LAST_STEP);

    // Advance the step; reload the duty on restart or at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step   <= '0;
            duty_q <= pct_t'(DEF_PCT);
        end else if (restart) begin
            step   <= '0;
            duty_q <= duty_in;
        end else if (wrap) begin
            step   <= '0;
            duty_q <= duty_in;
        end else if (tick) begin
            step   <= step + 1'b1;
        end
    end

    assign active = (step < duty_q);

    // R1: the step index stays within one period
    a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST_STEP);
    // R2: the latched duty is always within 1..100
    a_r2_duty_range: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q >= pct_t'(1)) && (duty_q <= pct_t'(MAX_PCT)));
    // R8: between boundaries the latched duty does not move
    a_r8_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !wrap) |=> $stable(duty_q));
    // R7: a restart always brings the period back to step zero
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (step == '0));
endmodule

// File: rtl/slow_pwm_gen.sv
// Top level of the slow indicator PWM. Combines the run condition
// (enable low, no faults, out of reset) with the step counters and drives
// an open-drain pad as constant-low data plus an output-enable.
// Assumes the fault and enable inputs are already synchronous to clk.
module slow_pwm_gen
    import spg_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned REQ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             uv_fault,
    input  logic             ot_fault,
    input  logic [REQ_W-1:0] duty_pct,
    input  logic             duty_unset,
    output logic             pad_o,
    output logic             pad_oe
);
    logic live_q;
    logic run;
    logic restart;
    logic tick;
    logic active;
    pct_t duty_eff;

    // Mark the first cycle after reset as live so a fresh period starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_q <= 1'b0;
        else
            live_q <= 1'b1;
    end

    assign run     = !en_n && !uv_fault && !ot_fault;
    assign restart = !live_q || !run;

    spg_duty_sel #(.REQ_W(REQ_W)) u_sel (
        .req   (duty_pct),
        .unset (duty_unset),
        .pct   (duty_eff)
    );

    spg_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    spg_period_ctr u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .duty_in (duty_eff),
        .active  (active)
    );

    assign pad_o  = 1'b0;
    assign pad_oe = live_q && run && active;

    // R5: enable high keeps the pad released
    a_r5_en_off: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> !pad_oe);
    // R6: any fault keeps the pad released
    a_r6_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_fault || ot_fault) |-> !pad_oe);
    // R3: the unset flag selects the 50% default
    a_r3_default: assert property (@(posedge clk) disable iff (!rst_n)
        duty_unset |-> (duty_eff == pct_t'(DEF_PCT)));
endmodule

// File: tb/tb_slow_pwm_gen.sv
module tb_slow_pwm_gen;
    localparam int CLK_HZ = 500;              // 10 cycles per step
    localparam int STEP   = CLK_HZ / 50;
    localparam int PERIOD = 100 * STEP;

    logic clk = 1'b0;
    logic rst_n, en_n, uv_fault, ot_fault, duty_unset;
    logic [7:0] duty_pct;
    logic pad_o, pad_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;                    // 50 MHz

    slow_pwm_gen #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .uv_fault(uv_fault),
        .ot_fault(ot_fault), .duty_pct(duty_pct), .duty_unset(duty_unset),
        .pad_o(pad_o), .pad_oe(pad_oe)
    );

    // {unset, request, expected on-cycles per period}
    localparam logic [19:0] VEC [8] = '{
        {1'b0, 8'd1,   11'd10},
        {1'b0, 8'd25,  11'd250},
        {1'b0, 8'd50,  11'd500},
        {1'b0, 8'd100, 11'd1000},
        {1'b1, 8'd7,   11'd500},
        {1'b0, 8'd0,   11'd10},
        {1'b0, 8'd200, 11'd1000},
        {1'b0, 8'd99,  11'd990}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold enable off for two edges, then run again; called at a negedge.
    task automatic restart_run();
        en_n = 1'b1;
        @(negedge clk); @(negedge clk);
        en_n = 1'b0;
        #1;
    endtask

    // Count pad_oe over one period, starting 1 ns after a negedge.
    task automatic measure(output int on);
        on = 0;
        for (int k = 0; k < PERIOD; k++) begin
            on += int'(pad_oe);
            @(negedge clk); #1;
        end
    endtask

    initial begin
        int on, on2;
        rst_n = 1'b0; en_n = 1'b0; uv_fault = 1'b0; ot_fault = 1'b0;
        duty_unset = 1'b0; duty_pct = 8'd10;
        @(negedge clk); @(negedge clk); #1;
        check("R9 pad released in reset", int'(pad_oe), 0);
        check("R10 pad data low", int'(pad_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R9 runs right after reset", int'(pad_oe), 1);

        // Table walk: R1 R2 R3 R4 on-time per period, two periods each
        for (int i = 0; i < 8; i++) begin
            duty_unset = VEC[i][19];
            duty_pct   = VEC[i][18:11];
            @(negedge clk);
            restart_run();
            measure(on);
            measure(on2);
            check($sformatf("R1/R2/R3 vector %0d first period", i), on, int'(VEC[i][10:0]));
            check($sformatf("R1/R2/R3/R4 vector %0d second period", i), on2, int'(VEC[i][10:0]));
        end

        // R8: mid-period change waits for the boundary
        duty_unset = 1'b0; duty_pct = 8'd20;
        @(negedge clk);
        restart_run();
        on = 0;
        for (int k = 0; k < PERIOD; k++) begin
            on += int'(pad_oe);
            if (k == 50) duty_pct = 8'd80;
            @(negedge clk); #1;
        end
        check("R8 old duty kept this period", on, 200);
        measure(on);
        check("R8 new duty next period", on, 800);

        // R5: enable high releases in the same cycle and holds
        duty_pct = 8'd100;
        @(negedge clk);
        restart_run();
        repeat (30) @(negedge clk);
        en_n = 1'b1; #1;
        check("R5 release on enable high", int'(pad_oe), 0);
        on = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); #1; on += int'(pad_oe); end
        check("R5 held off while disabled", on, 0);
        en_n = 1'b0; #1;
        check("R5 runs when enable low", int'(pad_oe), 1);

        // R6: each fault releases in the same cycle
        @(negedge clk);
        uv_fault = 1'b1; #1;
        check("R6 undervoltage releases", int'(pad_oe), 0);
        @(negedge clk);
        uv_fault = 1'b0; ot_fault = 1'b1; #1;
        check("R6 overtemperature releases", int'(pad_oe), 0);
        on = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); #1; on += int'(pad_oe); end
        check("R6 held off during fault", on, 0);
        ot_fault = 1'b0;

        // R7: fault mid-period, then a complete first period
        duty_pct = 8'd30;
        @(negedge clk);
        restart_run();
        repeat (150) @(negedge clk);
        uv_fault = 1'b1;
        @(negedge clk); @(negedge clk);
        uv_fault = 1'b0; #1;
        measure(on);
        check("R7 full period after recovery", on, 300);
        check("R10 pad data low at end", int'(pad_o), 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 150_000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule